// File: doc/BRIEF.md
# Periodic Down-Counter Timer with Register Port

This block is a small bus-attached timer. Software loads a 16-bit start value into a reload register, which also loads the counter at once. It then sets an enable bit in the control word. From then on the counter steps down by one on every cycle in which the timebase strobe `tick` is high. When the counter has reached zero, the next tick refills it from the reload register, so the count runs periodically with no further software action.

A reset bit in the control word returns the timer to its idle state. The current count can be read back at any time through the register port, and writes to it are ignored. The register port is synchronous and moves whole 32-bit words only. The window is 256 bytes wide and holds three registers: control at offset 0x00, reload at offset 0x04 and count at offset 0x08. In the control word, bit 0 is the reset request and bit 1 is the run request.

Top module: `periodic_down_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the control, reload and count registers clear to zero and the counter stops. Afterwards all three registers read as zero.
- R2: A write to offset 0x00 with bit 0 set clears the control, reload and count registers and stops the counter. The other bits of that word have no effect, including bit 1.
- R3: A write to offset 0x04 keeps only `wr_data[15:0]` as the reload value. A read of offset 0x04 returns that value zero-extended to 32 bits.
- R4: A write to offset 0x04 also loads the same 16-bit value into the counter at that clock edge. It takes priority over a tick in the same cycle.
- R5: A write to offset 0x00 with bit 0 clear stores the whole 32-bit word, and a read of offset 0x00 returns it. If bit 1 is set, the counter starts running. If bit 1 is clear, the counter's run state does not change.
- R6: While the counter is stopped, ticks leave the count unchanged.
- R7: While the counter is running, each clock edge with `tick` high and a nonzero count lowers the count by one. Edges with `tick` low leave the count unchanged.
- R8: While the counter is running, a tick that finds the count at zero loads the reload value. A reload value of N therefore gives a period of N+1 ticks.
- R9: Writes to offset 0x08 change neither the count nor any other register.
- R10: With a reload value of zero, a running counter stays at zero on every tick.
- R11: Reads of any offset other than 0x00, 0x04 and 0x08 return zero, and writes to such an offset are ignored. An address whose two low bits are not zero counts as unmapped.
- R12: `rd_data` takes the addressed register's value at the clock edge where `rd_en` is high. It holds that value while `rd_en` is low. The count seen is the value before that edge's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase strobe; one decrement opportunity per high cycle |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset within the register window |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |

## Verification
The bench builds the block with its default parameters: an 8-bit address, a 32-bit data word and a 16-bit counter. The 16-bit counter lets the bench write a 32-bit word with high bits set and see them dropped. The bench drives `tick` itself, one strobe at a time, so reload values of 0 to 5 make both a full wrap and the zero-reload case reachable within a few dozen cycles. It also lines a tick up with a reload write in the same cycle, and it checks a run request sent together with the reset bit.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned OFF_CTRL    = 'h00;
  localparam int unsigned OFF_RLD     = 'h04;
  localparam int unsigned OFF_CNT     = 'h08;
  localparam int unsigned CTRL_RST_BIT = 0;
  localparam int unsigned CTRL_RUN_BIT = 1;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_RLD  = 2'd2,
    SEL_CNT  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/tmr_decode.sv
module tmr_decode #(
  parameter int ADDR_W = 8
) (
  input  logic [ADDR_W-1:0] addr,
  output tmr_pkg::reg_sel_e sel
);
  import tmr_pkg::*;

  always_comb begin
    if (addr == ADDR_W'(OFF_CTRL))      sel = SEL_CTRL;
    else if (addr == ADDR_W'(OFF_RLD))  sel = SEL_RLD;
    else if (addr == ADDR_W'(OFF_CNT))  sel = SEL_CNT;
    else                                sel = SEL_NONE;
  end
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ctrl,
  input  logic [DATA_W-1:0] wr_data,
  output logic              soft_clr,
  output logic [DATA_W-1:0] ctrl_q,
  output logic              run_q
);
  import tmr_pkg::*;

  // reset request wins over every other bit of the same word
  assign soft_clr = wr_ctrl && wr_data[CTRL_RST_BIT];

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      ctrl_q <= '0;
      run_q  <= 1'b0;
    end else if (wr_ctrl) begin
      ctrl_q <= wr_data;
      if (wr_data[CTRL_RUN_BIT]) run_q <= 1'b1;
    end
  end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  input  logic             tick,
  output logic [CNT_W-1:0] rld_q,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic at_zero;
  assign at_zero = (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rld_q <= '0;
      cnt_q <= '0;
    end else if (load) begin
      rld_q <= load_val;
      cnt_q <= load_val;
    end else if (run && tick) begin
      cnt_q <= at_zero ? rld_q : (cnt_q - ONE);
    end
  end
endmodule

// File: rtl/tmr_rdmux.sv
module tmr_rdmux #(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  tmr_pkg::reg_sel_e sel,
  input  logic [DATA_W-1:0] ctrl_q,
  input  logic [CNT_W-1:0]  rld_q,
  input  logic [CNT_W-1:0]  cnt_q,
  output logic [DATA_W-1:0] rd_data
);
  import tmr_pkg::*;

  logic [DATA_W-1:0] mux_d;

  always_comb begin
    unique case (sel)
      SEL_CTRL: mux_d = ctrl_q;
      SEL_RLD:  mux_d = DATA_W'(rld_q);
      SEL_CNT:  mux_d = DATA_W'(cnt_q);
      default:  mux_d = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= mux_d;
  end
endmodule

// File: rtl/periodic_down_timer.sv
module periodic_down_timer #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  import tmr_pkg::*;

  reg_sel_e          sel;
  logic              soft_clr;
  logic [DATA_W-1:0] ctrl_q;
  logic              run_q;
  logic [CNT_W-1:0]  rld_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wr_ctrl;
  logic              wr_rld;

  assign wr_ctrl = wr_en && (sel == SEL_CTRL);
  assign wr_rld  = wr_en && (sel == SEL_RLD);

  tmr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr (addr),
    .sel  (sel)
  );

  tmr_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_ctrl  (wr_ctrl),
    .wr_data  (wr_data),
    .soft_clr (soft_clr),
    .ctrl_q   (ctrl_q),
    .run_q    (run_q)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst      (rst),
    .clr      (soft_clr),
    .load     (wr_rld),
    .load_val (wr_data[CNT_W-1:0]),
    .run      (run_q),
    .tick     (tick),
    .rld_q    (rld_q),
    .cnt_q    (cnt_q)
  );

  tmr_rdmux #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rd (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .sel     (sel),
    .ctrl_q  (ctrl_q),
    .rld_q   (rld_q),
    .cnt_q   (cnt_q),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic              wr_en,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic [DATA_W-1:0] ctrl_q,
  input logic              run_q,
  input logic [CNT_W-1:0]  rld_q,
  input logic [CNT_W-1:0]  cnt_q
);
  import tmr_pkg::*;

  logic mapped;
  assign mapped = (addr == ADDR_W'(OFF_CTRL)) || (addr == ADDR_W'(OFF_RLD)) ||
                  (addr == ADDR_W'(OFF_CNT));

  // R1
  hw_reset_chk: assert property (@(posedge clk)
    rst |=> (cnt_q == '0 && rld_q == '0 && ctrl_q == '0 && !run_q));

  // R2
  soft_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_CTRL) && wr_data[CTRL_RST_BIT])
      |=> (cnt_q == '0 && rld_q == '0 && ctrl_q == '0 && !run_q));

  // R4
  reload_load_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_RLD))
      |=> (cnt_q == $past(wr_data[CNT_W-1:0]) && rld_q == $past(wr_data[CNT_W-1:0])));

  // R6
  stopped_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !wr_en) |=> $stable(cnt_q));

  // R7
  step_down_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick && !wr_en && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

  // R8
  wrap_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && tick && !wr_en && cnt_q == '0) |=> (cnt_q == $past(rld_q)));

  // R9
  count_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(OFF_CNT) && !tick)
      |=> ($stable(cnt_q) && $stable(rld_q) && $stable(ctrl_q)));

  // R11
  unmapped_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !mapped) |=> (rd_data == '0));

  // R12
  read_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

bind periodic_down_timer tmr_chk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wr_data (wr_data),
  .rd_data (rd_data),
  .ctrl_q  (ctrl_q),
  .run_q   (run_q),
  .rld_q   (rld_q),
  .cnt_q   (cnt_q)
);

// File: tb/tb_periodic_down_timer.sv
module tb_periodic_down_timer;
  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_RLD  = 8'h04;
  localparam logic [7:0] A_CNT  = 8'h08;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  periodic_down_timer dut (
    .clk(clk), .rst(rst), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input bit with_tick = 0);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wr_data = d; tick = with_tick;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, rd_data, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic hw_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_reset_state();
    hw_reset();
    rd_chk("R1 ctrl", A_CTRL, 32'h0);
    rd_chk("R1 reload", A_RLD, 32'h0);
    rd_chk("R1 count", A_CNT, 32'h0);
  endtask

  task automatic t_reload_mask();
    wr(A_RLD, 32'hABCD_1234);
    rd_chk("R3 reload masked", A_RLD, 32'h0000_1234);
    rd_chk("R4 count loaded", A_CNT, 32'h0000_1234);
    wr(A_RLD, 32'hFFFF_FFFF);
    rd_chk("R3 count zero-extended", A_CNT, 32'h0000_FFFF);
  endtask

  task automatic t_stopped();
    ticks(3);
    rd_chk("R6 stopped count", A_CNT, 32'h0000_FFFF);
  endtask

  task automatic t_run_wrap();
    wr(A_CTRL, 32'h0000_0002);
    rd_chk("R5 ctrl stored", A_CTRL, 32'h0000_0002);
    wr(A_RLD, 32'h5);
    ticks(3);
    rd_chk("R7 after 3 ticks", A_CNT, 32'h2);
    repeat (4) @(negedge clk);
    rd_chk("R7 no tick no change", A_CNT, 32'h2);
    ticks(2);
    rd_chk("R8 reached zero", A_CNT, 32'h0);
    ticks(1);
    rd_chk("R8 reloaded", A_CNT, 32'h5);
    ticks(6);
    rd_chk("R8 period N+1", A_CNT, 32'h5);
  endtask

  task automatic t_count_write();
    wr(A_CNT, 32'h0000_0077);
    rd_chk("R9 count unchanged", A_CNT, 32'h5);
    rd_chk("R9 reload unchanged", A_RLD, 32'h5);
    rd_chk("R9 ctrl unchanged", A_CTRL, 32'h2);
  endtask

  task automatic t_ctrl_no_run();
    wr(A_CTRL, 32'hF0F0_0000);
    rd_chk("R5 word stored", A_CTRL, 32'hF0F0_0000);
    ticks(2);
    rd_chk("R5 keeps running", A_CNT, 32'h3);
  endtask

  task automatic t_load_vs_tick();
    wr(A_RLD, 32'h9, 1'b1);
    rd_chk("R4 load beats tick", A_CNT, 32'h9);
  endtask

  task automatic t_zero_reload();
    wr(A_RLD, 32'h0);
    ticks(4);
    rd_chk("R10 stays zero", A_CNT, 32'h0);
  endtask

  task automatic t_soft_reset();
    wr(A_RLD, 32'h4);
    wr(A_CTRL, 32'h0000_0003);
    rd_chk("R2 ctrl cleared", A_CTRL, 32'h0);
    rd_chk("R2 reload cleared", A_RLD, 32'h0);
    rd_chk("R2 count cleared", A_CNT, 32'h0);
    wr(A_RLD, 32'h7);
    ticks(3);
    rd_chk("R2 stopped after clear", A_CNT, 32'h7);
  endtask

  task automatic t_unmapped();
    wr(A_CTRL, 32'h0000_0002);
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h05, 32'h0000_1111);
    rd_chk("R11 write ignored ctrl", A_CTRL, 32'h2);
    rd_chk("R11 write ignored reload", A_RLD, 32'h7);
    rd_chk("R11 read 0x0C", 8'h0C, 32'h0);
    rd_chk("R11 read 0xFC", 8'hFC, 32'h0);
    rd_chk("R11 misaligned read", 8'h01, 32'h0);
  endtask

  task automatic t_read_hold();
    rd_chk("R12 read ctrl", A_CTRL, 32'h2);
    ticks(2);
    @(negedge clk);
    chk("R12 held without rd_en", rd_data, 32'h2);
  endtask

  task automatic t_hw_reset_running();
    hw_reset();
    rd_chk("R1 count after reset", A_CNT, 32'h0);
    wr(A_RLD, 32'h3);
    ticks(2);
    rd_chk("R1 stopped after reset", A_CNT, 32'h3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset_state();
    t_reload_mask();
    t_stopped();
    t_run_wrap();
    t_count_write();
    t_ctrl_no_run();
    t_load_vs_tick();
    t_zero_reload();
    t_soft_reset();
    t_unmapped();
    t_read_hold();
    t_hw_reset_running();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 20000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule